// File: doc/BRIEF.md
# Descriptor-chain lookup-table refill engine

This block rewrites rectangular windows of a two-dimensional address-translation table. Software writes the address of the first descriptor in a linked chain, and the engine works through the chain on its own. For each descriptor it reads four words: the rectangle, a control word that selects the table, the address of the data block, and the address of the next descriptor. It then streams the data block from memory and writes one page entry to each slot of the rectangle, in row-major order. The walk stops when it meets a null next pointer, and the engine then posts a completion interrupt.

Three ports connect it to the rest of the chip: a small register port, a word-wide memory read port with a valid/ready handshake, and a write-only port into the table storage. Each table is `TBL_W` slots wide and `TBL_H` slots tall. There are `NUM_TBL` tables, placed one after another in the index space. A write of zero to the chain register cancels a walk that is in progress. Software must not start a new chain until the status register shows the engine ready.

Top module: `lut_refill_engine`

## Requirements
- R1: After reset the status register (address 1) reads 1, meaning ready=bit0 and error=bit1 clear. The interrupt status (address 2) and enable (address 3) registers read 0, `irq` is low, and no memory read or table write is issued.
- R2: A write of a nonzero, 16-byte-aligned address to the chain register (address 0) while ready starts a walk. Ready reads 0 from the next cycle, and the first four memory reads are at start, start+4, start+8 and start+12. Those words are, in order: the rectangle {y1[31:24], x1[23:16], y0[15:8], x0[7:0]}, the control word with the table id in bits [3:0], the data block address, and the next descriptor address.
- R3: The data block supplies (x1-x0+1)*(y1-y0+1) words. Word k is read from data+4k and is written to table index tid*TBL_W*TBL_H + (y0+r)*TBL_W + (x0+c), with k = r*(x1-x0+1)+c, walking columns first and rows second.
- R4: A nonzero next address is fetched as the next descriptor. A zero next address ends the chain, and ready reads 1 starting in the cycle after the final table write.
- R5: Interrupt status bit1 (last) is set when a chain completes, and bit0 (descriptor done) is set after each descriptor. Writing a 1 to a status bit clears it. `irq` equals the OR of (status AND enable) over bits [1:0].
- R6: Writing zero to the chain register aborts a walk. No table write happens in that cycle or afterwards, ready and error read 0b01 from the next cycle, and the last bit is not set.
- R7: A nonzero start address with bits [3:0] not all zero, written while ready, sets error. The engine stays ready and issues no memory read.
- R8: A nonzero chain write while the engine is busy is ignored. The running chain writes exactly its own entries.
- R9: A descriptor is rejected if x0>x1, y0>y1, x1>=TBL_W, y1>=TBL_H, tid>=NUM_TBL, the data address is not 16-byte aligned, or the next address is nonzero and not 16-byte aligned. On rejection the engine sets error, writes none of that descriptor's entries, leaves the last bit clear and returns to ready.
- R10: While a memory read is pending and not accepted, `mem_rd_valid` stays high and `mem_rd_addr` holds its value.
- R11: An accepted start clears the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register write address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 2 | Register read address |
| reg_rd_data | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| mem_rd_valid | output | 1 | Memory read request valid |
| mem_rd_addr | output | ADDR_W | Byte address of the requested word |
| mem_rd_ready | input | 1 | Memory accepts the request; data is valid this cycle |
| mem_rd_data | input | 32 | Read word |
| tbl_wr_en | output | 1 | Table write strobe |
| tbl_wr_idx | output | IDX_W | Flat table slot index |
| tbl_wr_data | output | 32 | Page entry written |

## Verification
The embedded properties check four things on every cycle: a stalled read request is held steady, an accepted start drops ready, every table write lands inside the current rectangle, and the register effects of aborts, misaligned starts and write-one-to-clear take hold. Other behaviours show only over a whole scenario, so the bench scenarios cover them: the exact order and values of the written entries, following next pointers, the timing of ready after the last write, ignored writes while busy, and rejection of each kind of malformed descriptor partway through a chain. Randomly generated chains under random memory stalls are compared word by word against a sequence that the bench builds from the descriptors.

// File: rtl/lre_pkg.sv
package lre_pkg;
  typedef enum logic [1:0] {W_IDLE, W_DESC, W_CHECK, W_DATA} walk_st_e;

  localparam logic [1:0] REG_CHAIN = 2'd0;
  localparam logic [1:0] REG_STAT  = 2'd1;
  localparam logic [1:0] REG_ISTAT = 2'd2;
  localparam logic [1:0] REG_IEN   = 2'd3;

  localparam int IRQ_DESC = 0;
  localparam int IRQ_LAST = 1;

  typedef struct packed {
    logic [7:0] y1;
    logic [7:0] x1;
    logic [7:0] y0;
    logic [7:0] x0;
  } rect_t;
endpackage

// File: rtl/lre_regs.sv
module lre_regs
  import lre_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [1:0]        rd_addr,
  output logic [31:0]       rd_data,
  input  logic              walk_ready,
  input  logic              err_set,
  input  logic              desc_done,
  input  logic              chain_done,
  output logic              start,
  output logic              abort,
  output logic [ADDR_W-1:0] start_addr,
  output logic              irq
);
  logic       err_q, err_d;
  logic [1:0] ist_q, ist_d;
  logic [1:0] ien_q, ien_d;
  logic       wr_chain, wr_ist, wr_ien, nonzero, misalg;

  assign wr_chain   = wr_en && (wr_addr == REG_CHAIN);
  assign wr_ist     = wr_en && (wr_addr == REG_ISTAT);
  assign wr_ien     = wr_en && (wr_addr == REG_IEN);
  assign nonzero    = (wr_data != 32'd0);
  assign abort      = wr_chain && !nonzero;
  assign start      = wr_chain && nonzero && (wr_data[3:0] == 4'd0) && walk_ready;
  assign misalg     = wr_chain && nonzero && (wr_data[3:0] != 4'd0) && walk_ready;
  assign start_addr = wr_data[ADDR_W-1:0];

  always_comb begin
    err_d = err_q;
    if (abort || start)        err_d = 1'b0;
    else if (misalg || err_set) err_d = 1'b1;
    ist_d = (ist_q & ~(wr_ist ? wr_data[1:0] : 2'b00)) | {chain_done, desc_done};
    ien_d = wr_ien ? wr_data[1:0] : ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      ist_q <= 2'b00;
      ien_q <= 2'b00;
    end else begin
      err_q <= err_d;
      ist_q <= ist_d;
      ien_q <= ien_d;
    end
  end

  assign irq = |(ist_q & ien_q);

  always_comb begin
    case (rd_addr)
      REG_STAT:  rd_data = {30'd0, err_q, walk_ready};
      REG_ISTAT: rd_data = {30'd0, ist_q};
      REG_IEN:   rd_data = {30'd0, ien_q};
      default:   rd_data = 32'd0;
    endcase
  end

  // R7: misaligned start flags error and leaves the engine idle
  p_misalign_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    misalg |=> (err_q && walk_ready));

  // R6: abort returns the engine to ready with error clear
  p_abort_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (walk_ready && !err_q));

  // R5: write-one-to-clear of the last bit
  p_w1c_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ist && wr_data[IRQ_LAST] && !chain_done) |=> !ist_q[IRQ_LAST]);

  // R11: an accepted start clears the error flag
  p_start_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !err_q);
endmodule

// File: rtl/lre_idx_gen.sv
module lre_idx_gen #(
  parameter int TBL_W   = 16,
  parameter int TBL_H   = 8,
  parameter int NUM_TBL = 2,
  localparam int PLANE  = TBL_W * TBL_H,
  localparam int IDX_W  = $clog2(PLANE * NUM_TBL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic [7:0]       x0,
  input  logic [7:0]       y0,
  input  logic [7:0]       x1,
  input  logic [7:0]       y1,
  input  logic [3:0]       tid,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  logic [7:0] col_q, col_d, row_q, row_d;
  logic [7:0] col_span, row_span;
  logic       row_end;

  assign col_span = x1 - x0;
  assign row_span = y1 - y0;
  assign row_end  = (col_q == col_span);
  assign last     = row_end && (row_q == row_span);

  always_comb begin
    col_d = col_q;
    row_d = row_q;
    if (load) begin
      col_d = 8'd0;
      row_d = 8'd0;
    end else if (adv) begin
      if (row_end) begin
        col_d = 8'd0;
        row_d = row_q + 8'd1;
      end else begin
        col_d = col_q + 8'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= 8'd0;
      row_q <= 8'd0;
    end else if (load || adv) begin
      col_q <= col_d;
      row_q <= row_d;
    end
  end

  assign idx = IDX_W'(tid) * IDX_W'(PLANE)
             + (IDX_W'(y0) + IDX_W'(row_q)) * IDX_W'(TBL_W)
             + IDX_W'(x0) + IDX_W'(col_q);

  // R3: every written slot lies inside the current rectangle
  p_in_rect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> ((9'(x0) + 9'(col_q)) <= 9'(x1)) && ((9'(y0) + 9'(row_q)) <= 9'(y1)));
endmodule

// File: rtl/lre_walker.sv
module lre_walker
  import lre_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int TBL_W   = 16,
  parameter int TBL_H   = 8,
  parameter int NUM_TBL = 2,
  localparam int IDX_W  = $clog2(TBL_W * TBL_H * NUM_TBL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ready,
  input  logic [31:0]       rd_data,
  output logic              tw_en,
  output logic [IDX_W-1:0]  tw_idx,
  output logic [31:0]       tw_data,
  output logic              ready,
  output logic              err_set,
  output logic              desc_done,
  output logic              chain_done
);
  walk_st_e          st_q, st_d;
  logic [1:0]        wcnt_q, wcnt_d;
  logic [ADDR_W-1:0] ptr_q, ptr_nx, dptr_q, dptr_nx, next_q;
  rect_t             rect_q;
  logic [3:0]        tid_q;
  logic              ptr_ld, rect_ld, tid_ld, dptr_ld, next_ld;
  logic              gen_load, gen_adv, gen_last, bad;

  lre_idx_gen #(.TBL_W(TBL_W), .TBL_H(TBL_H), .NUM_TBL(NUM_TBL)) u_idx (
    .clk(clk), .rst_n(rst_n), .load(gen_load), .adv(gen_adv),
    .x0(rect_q.x0), .y0(rect_q.y0), .x1(rect_q.x1), .y1(rect_q.y1),
    .tid(tid_q), .idx(tw_idx), .last(gen_last)
  );

  assign bad = (rect_q.x0 > rect_q.x1) || (rect_q.y0 > rect_q.y1)
            || (32'(rect_q.x1) >= 32'(TBL_W)) || (32'(rect_q.y1) >= 32'(TBL_H))
            || (32'(tid_q) >= 32'(NUM_TBL)) || (dptr_q[3:0] != 4'd0)
            || ((next_q != '0) && (next_q[3:0] != 4'd0));

  assign ready   = (st_q == W_IDLE);
  assign tw_data = rd_data;

  always_comb begin
    st_d = st_q;  wcnt_d = wcnt_q;
    ptr_ld = 1'b0;  ptr_nx = start_addr;
    rect_ld = 1'b0; tid_ld = 1'b0; next_ld = 1'b0;
    dptr_ld = 1'b0; dptr_nx = rd_data[ADDR_W-1:0];
    rd_valid = 1'b0; rd_addr = ptr_q + ADDR_W'({wcnt_q, 2'b00});
    tw_en = 1'b0; gen_load = 1'b0; gen_adv = 1'b0;
    err_set = 1'b0; desc_done = 1'b0; chain_done = 1'b0;
    case (st_q)
      W_IDLE: begin
        if (start) begin
          st_d = W_DESC; wcnt_d = 2'd0; ptr_ld = 1'b1;
        end
      end
      W_DESC: begin
        rd_valid = 1'b1;
        if (rd_ready) begin
          wcnt_d = wcnt_q + 2'd1;
          case (wcnt_q)
            2'd0: rect_ld = 1'b1;
            2'd1: tid_ld  = 1'b1;
            2'd2: dptr_ld = 1'b1;
            default: begin next_ld = 1'b1; st_d = W_CHECK; end
          endcase
        end
      end
      W_CHECK: begin
        if (bad) begin
          err_set = 1'b1; st_d = W_IDLE;
        end else begin
          gen_load = 1'b1; st_d = W_DATA;
        end
      end
      default: begin
        rd_valid = 1'b1;
        rd_addr  = dptr_q;
        if (rd_ready) begin
          tw_en = 1'b1; gen_adv = 1'b1;
          dptr_ld = 1'b1; dptr_nx = dptr_q + ADDR_W'(4);
          if (gen_last) begin
            desc_done = 1'b1;
            if (next_q == '0) begin
              chain_done = 1'b1; st_d = W_IDLE;
            end else begin
              ptr_ld = 1'b1; ptr_nx = next_q; wcnt_d = 2'd0; st_d = W_DESC;
            end
          end
        end
      end
    endcase
    if (abort) begin
      st_d = W_IDLE; tw_en = 1'b0; gen_adv = 1'b0;
      err_set = 1'b0; desc_done = 1'b0; chain_done = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      wcnt_q <= 2'd0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ptr_ld)  ptr_q  <= ptr_nx;
    if (rect_ld) rect_q <= rect_t'(rd_data);
    if (tid_ld)  tid_q  <= rd_data[3:0];
    if (dptr_ld) dptr_q <= dptr_nx;
    if (next_ld) next_q <= rd_data[ADDR_W-1:0];
  end

  // R10: a stalled read request keeps valid and address steady
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !abort) |=> (rd_valid && $stable(rd_addr)));

  // R2: an accepted start makes the engine busy
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready);

  // R6: after an abort no read request is outstanding
  p_abort_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !rd_valid);

  // R2: reads are word aligned
  p_rd_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_addr[1:0] == 2'b00));
endmodule

// File: rtl/lut_refill_engine.sv
module lut_refill_engine #(
  parameter int ADDR_W  = 32,
  parameter int TBL_W   = 16,
  parameter int TBL_H   = 8,
  parameter int NUM_TBL = 2,
  localparam int IDX_W  = $clog2(TBL_W * TBL_H * NUM_TBL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_wr_addr,
  input  logic [31:0]       reg_wr_data,
  input  logic [1:0]        reg_rd_addr,
  output logic [31:0]       reg_rd_data,
  output logic              irq,
  output logic              mem_rd_valid,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ready,
  input  logic [31:0]       mem_rd_data,
  output logic              tbl_wr_en,
  output logic [IDX_W-1:0]  tbl_wr_idx,
  output logic [31:0]       tbl_wr_data
);
  logic              start, abort, walk_ready, err_set, desc_done, chain_done;
  logic [ADDR_W-1:0] start_addr;

  lre_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
    .walk_ready(walk_ready), .err_set(err_set),
    .desc_done(desc_done), .chain_done(chain_done),
    .start(start), .abort(abort), .start_addr(start_addr), .irq(irq)
  );

  lre_walker #(.ADDR_W(ADDR_W), .TBL_W(TBL_W), .TBL_H(TBL_H), .NUM_TBL(NUM_TBL)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .start(start), .abort(abort), .start_addr(start_addr),
    .rd_valid(mem_rd_valid), .rd_addr(mem_rd_addr),
    .rd_ready(mem_rd_ready), .rd_data(mem_rd_data),
    .tw_en(tbl_wr_en), .tw_idx(tbl_wr_idx), .tw_data(tbl_wr_data),
    .ready(walk_ready), .err_set(err_set),
    .desc_done(desc_done), .chain_done(chain_done)
  );
endmodule

// File: tb/tb_lut_refill_engine.sv
module tb_lut_refill_engine;
  localparam int TW = 16, TH = 8, NT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_wr_addr = 2'd0;
  logic [31:0] reg_wr_data = 32'd0;
  logic [1:0]  reg_rd_addr = 2'd1;
  logic [31:0] reg_rd_data;
  logic        irq;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_data;
  logic        tbl_wr_en;
  logic [7:0]  tbl_wr_idx;
  logic [31:0] tbl_wr_data;

  lut_refill_engine dut (.*);

  always #10 clk = ~clk;

  logic [31:0] mem [0:4095];
  assign mem_rd_data = mem[mem_rd_addr[13:2]];

  int total = 0, bad = 0, cyc = 0, stall = 0;
  int obs_n = 0, rd_n = 0, last_wr_cyc = 0;
  int obs_idx [0:16383];
  int obs_dat [0:16383];
  int rd_log  [0:16383];
  int exp_n;
  int exp_idx [0:2047];
  int exp_dat [0:2047];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    mem_rd_ready = (stall == 0) ? 1'b1 : (($urandom % 4) != 0);
    #1;
    if (rst_n && tbl_wr_en) begin
      obs_idx[obs_n % 16384] = int'(tbl_wr_idx);
      obs_dat[obs_n % 16384] = int'(tbl_wr_data);
      obs_n = obs_n + 1;
      last_wr_cyc = cyc;
    end
    if (rst_n && mem_rd_valid && mem_rd_ready) begin
      rd_log[rd_n % 16384] = int'(mem_rd_addr);
      rd_n = rd_n + 1;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad = bad + 1;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  function automatic logic [31:0] reg_rd(input logic [1:0] a);
    reg_rd_addr = a;
    return reg_rd_data;
  endfunction

  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    reg_rd_addr = a;
    #2;
    d = reg_rd_data;
  endtask

  task automatic wait_ready(output int at_cyc);
    logic [31:0] s;
    at_cyc = -1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      peek(2'd1, s);
      if (s[0]) begin at_cyc = cyc; break; end
    end
  endtask

  // descriptor in memory; expected writes appended when add_exp is set
  task automatic put_desc(input int a, input int x0, input int y0, input int x1, input int y1,
                          input int tid, input int data, input int nxt, input bit add_exp);
    mem[a/4]     = {8'(y1), 8'(x1), 8'(y0), 8'(x0)};
    mem[a/4 + 1] = 32'(tid);
    mem[a/4 + 2] = 32'(data);
    mem[a/4 + 3] = 32'(nxt);
    if (add_exp) begin
      for (int r = 0; r <= y1 - y0; r++)
        for (int c = 0; c <= x1 - x0; c++) begin
          int k;
          k = r * (x1 - x0 + 1) + c;
          mem[data/4 + k] = $urandom;
          exp_idx[exp_n] = tid * TW * TH + (y0 + r) * TW + (x0 + c);
          exp_dat[exp_n] = int'(mem[data/4 + k]);
          exp_n = exp_n + 1;
        end
    end
  endtask

  task automatic cmp_seq(input int base, input string req);
    int n, first;
    n = obs_n - base;
    chk(n == exp_n, {req, " write count"}, n, exp_n);
    first = -1;
    for (int i = 0; i < exp_n && i < n; i++)
      if (first < 0 && (obs_idx[(base+i)%16384] != exp_idx[i] || obs_dat[(base+i)%16384] != exp_dat[i]))
        first = i;
    if (first >= 0)
      chk(1'b0, {req, " write sequence (index)"}, obs_idx[(base+first)%16384], exp_idx[first]);
    else
      chk(1'b1, req, 0, 0);
  endtask

  initial begin
    logic [31:0] s;
    int base, rbase, rc, nd, en;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 4096; i++) mem[i] = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(2'd1, s); chk(s == 32'd1, "R1 status", int'(s), 1);
    peek(2'd2, s); chk(s == 32'd0, "R1 irq status", int'(s), 0);
    peek(2'd3, s); chk(s == 32'd0, "R1 irq enable", int'(s), 0);
    chk(!irq && !mem_rd_valid && !tbl_wr_en, "R1 idle outputs", int'({irq, mem_rd_valid, tbl_wr_en}), 0);

    // R2 R3 R4 R5: single descriptor
    exp_n = 0;
    put_desc(32'h100, 2, 1, 4, 3, 1, 32'h1000, 0, 1'b1);
    base = obs_n; rbase = rd_n;
    reg_wr(2'd0, 32'h100);
    peek(2'd1, s); chk(s[0] == 1'b0, "R2 ready drops after start", int'(s), 0);
    wait_ready(rc);
    for (int i = 0; i < 4; i++)
      chk(rd_log[rbase + i] == 32'h100 + 4*i, "R2 descriptor word address", rd_log[rbase+i], 32'h100 + 4*i);
    chk(rd_log[rbase + 4] == 32'h1000, "R3 data block address", rd_log[rbase+4], 32'h1000);
    cmp_seq(base, "R3 single rectangle");
    chk(rc == last_wr_cyc + 1, "R4 ready after final write", rc, last_wr_cyc + 1);
    peek(2'd2, s); chk(s == 32'd3, "R5 last and desc bits", int'(s), 3);
    #1 chk(irq == 1'b0, "R5 irq masked", int'(irq), 0);
    reg_wr(2'd3, 32'd2);
    #2 chk(irq == 1'b1, "R5 irq enabled on last", int'(irq), 1);
    reg_wr(2'd2, 32'd2);
    peek(2'd2, s); chk(s == 32'd1, "R5 write-one clears last only", int'(s), 1);
    chk(irq == 1'b0, "R5 irq drops after clear", int'(irq), 0);
    reg_wr(2'd2, 32'd3);
    reg_wr(2'd3, 32'd0);

    // R4 two descriptors linked, with memory stalls
    stall = 1;
    exp_n = 0;
    put_desc(32'h100, 0, 0, 15, 0, 0, 32'h1000, 32'h140, 1'b1);
    put_desc(32'h140, 5, 6, 6, 7, 1, 32'h1200, 0, 1'b1);
    base = obs_n; rbase = rd_n;
    reg_wr(2'd0, 32'h100);
    wait_ready(rc);
    chk(rd_log[rbase + 20] == 32'h140, "R4 next descriptor fetched", rd_log[rbase+20], 32'h140);
    cmp_seq(base, "R4 two-descriptor chain");
    chk(rc == last_wr_cyc + 1, "R4 ready after final write (stalled)", rc, last_wr_cyc + 1);
    reg_wr(2'd2, 32'd3);

    // R7 misaligned start, then R11 clear on valid start
    rbase = rd_n;
    reg_wr(2'd0, 32'h108);
    peek(2'd1, s); chk(s == 32'd3, "R7 error set, still ready", int'(s), 3);
    repeat (3) @(negedge clk);
    chk(rd_n == rbase, "R7 no memory reads", rd_n - rbase, 0);
    exp_n = 0;
    put_desc(32'h100, 3, 3, 3, 3, 0, 32'h1000, 0, 1'b1);
    base = obs_n;
    reg_wr(2'd0, 32'h100);
    peek(2'd1, s); chk(s == 32'd0, "R11 error cleared by start", int'(s), 0);
    wait_ready(rc);
    cmp_seq(base, "R11 chain after error");
    reg_wr(2'd2, 32'd3);

    // R8 write while busy is ignored
    exp_n = 0;
    put_desc(32'h100, 0, 0, 7, 3, 1, 32'h2000, 0, 1'b1);
    put_desc(32'h200, 0, 0, 15, 7, 0, 32'h3000, 0, 1'b0);
    base = obs_n;
    reg_wr(2'd0, 32'h100);
    repeat (6) @(negedge clk);
    reg_wr(2'd0, 32'h200);
    wait_ready(rc);
    cmp_seq(base, "R8 busy write ignored");
    reg_wr(2'd2, 32'd3);

    // R6 abort mid-chain
    put_desc(32'h100, 0, 0, 15, 7, 0, 32'h2000, 0, 1'b0);
    reg_wr(2'd0, 32'h100);
    repeat (20) @(negedge clk);
    reg_wr(2'd0, 32'd0);
    base = obs_n;
    peek(2'd1, s); chk(s == 32'd1, "R6 ready, no error after abort", int'(s), 1);
    repeat (10) @(negedge clk);
    chk(obs_n == base, "R6 no writes after abort", obs_n - base, 0);
    peek(2'd2, s); chk(s[1] == 1'b0, "R6 last bit not set", int'(s), 0);
    reg_wr(2'd2, 32'd3);

    // R9 malformed second descriptor, six variants
    for (int v = 0; v < 6; v++) begin
      exp_n = 0;
      put_desc(32'h100, 1, 1, 2, 2, 0, 32'h1000, 32'h140, 1'b1);
      case (v)
        0: put_desc(32'h140, 5, 0, 4, 0, 0, 32'h1200, 0, 1'b0);
        1: put_desc(32'h140, 0, 0, 16, 0, 0, 32'h1200, 0, 1'b0);
        2: put_desc(32'h140, 0, 0, 1, 8, 0, 32'h1200, 0, 1'b0);
        3: put_desc(32'h140, 0, 0, 1, 1, 2, 32'h1200, 0, 1'b0);
        4: put_desc(32'h140, 0, 0, 1, 1, 0, 32'h1204, 0, 1'b0);
        default: put_desc(32'h140, 0, 0, 1, 1, 0, 32'h1200, 32'h188, 1'b0);
      endcase
      base = obs_n;
      reg_wr(2'd0, 32'h100);
      wait_ready(rc);
      peek(2'd1, s); chk(s == 32'd3, "R9 error on bad descriptor", int'(s), 3);
      cmp_seq(base, "R9 only the valid descriptor written");
      peek(2'd2, s); chk(s == 32'd1, "R9 last bit clear", int'(s), 1);
      reg_wr(2'd2, 32'd3);
    end

    // R3 R4 R5 random chains
    for (int t = 0; t < 20; t++) begin
      exp_n = 0;
      nd = 1 + ($urandom % 3);
      for (int j = 0; j < nd; j++) begin
        int x0, y0, x1, y1;
        x0 = $urandom % TW; x1 = x0 + ($urandom % (TW - x0));
        y0 = $urandom % TH; y1 = y0 + ($urandom % (TH - y0));
        put_desc(32'h100 + 16*j, x0, y0, x1, y1, $urandom % NT, 32'h1000 + 32'h200*j,
                 (j == nd - 1) ? 0 : 32'h100 + 16*(j+1), 1'b1);
      end
      en = $urandom % 4;
      reg_wr(2'd3, 32'(en));
      base = obs_n;
      reg_wr(2'd0, 32'h100);
      wait_ready(rc);
      cmp_seq(base, "R3 random chain");
      peek(2'd2, s); chk(s == 32'd3, "R5 random chain status", int'(s), 3);
      chk(irq == (en != 0), "R5 random irq", int'(irq), int'(en != 0));
      reg_wr(2'd2, 32'd3);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule